// File: doc/BRIEF.md
# Global 64-bit Timer with Self-Rearming Comparator

A memory-mapped timer block with a 64-bit free-running up counter and one 64-bit comparator. Software loads the counter and the comparator as 32-bit halves, starts the count through a control register, and gets a level interrupt when the count reaches the comparator value. The comparator either fires once, or adds an interval register to its own value after every hit, which gives a steady stream of interrupts without software rewriting the compare value.

Writes to the counter halves, comparator halves, interval and control register go through a fixed synchronisation pipeline and land `SYNC_DLY` clocks later. Each of those targets has its own sticky completion flag that rises on the landing cycle. Software polls the flag and then clears it by writing a 1 to it. The interrupt status, interrupt enable and completion-flag registers take their writes at once. Reads are combinational from the address and return live values.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: A write to counter low (0x100), counter high (0x104), comparator low (0x200), comparator high (0x204), interval (0x208) or control (0x240) is written at clock edge E0 and becomes visible at edge E0+`SYNC_DLY`. Reads before that edge return the old value.
- R3: Each delayed write sets its completion flag on the landing edge. The counter flags are bits 0 (low) and 1 (high) at 0x110. The comparator flags are bits 0 (low), 1 (high) and 2 (interval) at 0x24C, and bit 16 of 0x24C is the control flag. A flag stays set until a write of 1 to that bit, and writing 0 to a bit leaves it unchanged.
- R4: While control bit 8 (run) is 1, the counter rises by one every clock. While it is 0, the counter holds.
- R5: The counter wraps from 2^64-1 to 0.
- R6: A counter half load replaces only that 32-bit half, and on its landing edge it takes priority over the increment.
- R7: When control bit 0 (compare enable) is 1 and the counter equals the comparator at a clock edge, interrupt status bit 0 at 0x244 is 1 after that edge. With compare enable at 0, no match is flagged.
- R8: On a match with control bit 1 (auto-increment) set, the comparator becomes comparator + interval (mod 2^64) at the same edge. With that bit clear, the comparator is unchanged.
- R9: Interrupt status is sticky. Writing 1 to bit 0 of 0x244 clears it, and writing 0 does not.
- R10: `irq` is high exactly when interrupt status bit 0 and interrupt enable bit 0 at 0x248 are both 1.
- R11: Counter reads are live. A high/low/high read sequence with equal high values yields a consistent 64-bit value, including across a carry out of the low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The in-design properties assume that at most one delayed write lands per cycle, and the bench issues at most one bus write per clock. They also assume that no comparator load lands in the same cycle as an auto-increment hit. The bench meets this by stopping the timer, or clearing compare enable, before it reprograms the comparator. For periodic rounds the interval is kept at 6 or above, so the single-cycle status clear never coincides with the next hit.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned CNT_W  = 2 * HALF_W;

  localparam logic [REG_AW-1:0] A_CNT_LO  = 12'h100;
  localparam logic [REG_AW-1:0] A_CNT_HI  = 12'h104;
  localparam logic [REG_AW-1:0] A_CNT_WST = 12'h110;
  localparam logic [REG_AW-1:0] A_CMP_LO  = 12'h200;
  localparam logic [REG_AW-1:0] A_CMP_HI  = 12'h204;
  localparam logic [REG_AW-1:0] A_IVAL    = 12'h208;
  localparam logic [REG_AW-1:0] A_CTRL    = 12'h240;
  localparam logic [REG_AW-1:0] A_ISTAT   = 12'h244;
  localparam logic [REG_AW-1:0] A_IEN     = 12'h248;
  localparam logic [REG_AW-1:0] A_GWST    = 12'h24C;

  localparam int unsigned CTL_RUN_BIT   = 8;
  localparam int unsigned CTL_AUTO_BIT  = 1;
  localparam int unsigned CTL_CMPEN_BIT = 0;
  localparam int unsigned CTL_WST_BIT   = 16;

  typedef enum logic [2:0] {
    T_CNT_LO = 3'd0,
    T_CNT_HI = 3'd1,
    T_CMP_LO = 3'd2,
    T_CMP_HI = 3'd3,
    T_IVAL   = 3'd4,
    T_CTRL   = 3'd5
  } tgt_e;
  localparam int unsigned N_TGT = 6;

  typedef struct packed {
    logic              vld;
    tgt_e              tgt;
    logic [HALF_W-1:0] data;
  } wr_req_t;

  // replace one 32-bit half of a 64-bit value
  function automatic logic [CNT_W-1:0] put_half(input logic [CNT_W-1:0] cur,
                                                 input logic hi,
                                                 input logic [HALF_W-1:0] d);
    logic [CNT_W-1:0] r;
    r = cur;
    if (hi) r[CNT_W-1:HALF_W] = d;
    else    r[HALF_W-1:0]     = d;
    return r;
  endfunction

  // next compare point in periodic mode, modulo 2^64
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] base,
                                                input logic [CNT_W-1:0] step);
    return base + step;
  endfunction
endpackage

// File: rtl/tmr_wr_sync.sv
module tmr_wr_sync
  import gtc_pkg::*;
#(
  parameter int unsigned DLY = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_req_t req_in,
  output wr_req_t req_out
);
  wr_req_t stg [DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DLY); i++) stg[i] <= '0;
    end else begin
      stg[0] <= req_in;
      for (int i = 1; i < int'(DLY); i++) stg[i] <= stg[i-1];
    end
  end

  assign req_out = stg[DLY-1];
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import gtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (ld_lo)      cnt_nxt = put_half(cnt, 1'b0, ld_data);
    else if (ld_hi) cnt_nxt = put_half(cnt, 1'b1, ld_data);
    else if (run)   cnt_nxt = cnt + CNT_W'(1);
    else            cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R4 R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ld_lo && !ld_hi |=> cnt == $past(cnt) + CNT_W'(1));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ld_lo && !ld_hi |=> $stable(cnt));

  // R6
  count_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> cnt[HALF_W-1:0] == $past(ld_data) && cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W]));
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp
  import gtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cmp_en,
  input  logic              auto_inc,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_iv,
  input  logic [HALF_W-1:0] ld_data,
  input  logic              clr_stat,
  output logic [CNT_W-1:0]  cmp,
  output logic [CNT_W-1:0]  ival,
  output logic              stat,
  output logic              hit
);
  logic cmp_ld;

  assign hit    = cmp_en && (cnt == cmp);
  assign cmp_ld = ld_lo || ld_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      ival <= '0;
      stat <= 1'b0;
    end else begin
      if (ld_lo)                cmp <= put_half(cmp, 1'b0, ld_data);
      else if (ld_hi)           cmp <= put_half(cmp, 1'b1, ld_data);
      else if (hit && auto_inc) cmp <= advance(cmp, ival);
      if (ld_iv) ival <= put_half(ival, 1'b0, ld_data);
      if (hit)           stat <= 1'b1;
      else if (clr_stat) stat <= 1'b0;
    end
  end

  // R7
  hit_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat);

  // R8
  auto_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && auto_inc && !cmp_ld |=> cmp == $past(cmp) + $past(ival));

  // R8
  oneshot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !auto_inc && !cmp_ld |=> $stable(cmp));

  // R9
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat && !clr_stat |=> stat);

  // R7
  no_spurious_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat && !hit |=> !stat);
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
  import gtc_pkg::*;
#(
  parameter int unsigned SYNC_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq
);
  wr_req_t          req_in, req_land;
  logic             tgt_ok;
  tgt_e             tgt_sel;
  logic [N_TGT-1:0] land;

  logic             ctl_run, ctl_auto, ctl_en, ien;
  logic [1:0]       cnt_wst;
  logic [2:0]       cmp_wst;
  logic             ctl_wst;
  logic             w_cwst, w_gwst, clr_stat;

  logic [CNT_W-1:0] cnt, cmp, ival;
  logic             stat, hit;

  // decode writes that travel through the sync pipeline
  always_comb begin
    tgt_ok  = 1'b1;
    tgt_sel = T_CNT_LO;
    case (bus_addr)
      A_CNT_LO: tgt_sel = T_CNT_LO;
      A_CNT_HI: tgt_sel = T_CNT_HI;
      A_CMP_LO: tgt_sel = T_CMP_LO;
      A_CMP_HI: tgt_sel = T_CMP_HI;
      A_IVAL:   tgt_sel = T_IVAL;
      A_CTRL:   tgt_sel = T_CTRL;
      default:  tgt_ok  = 1'b0;
    endcase
    req_in.vld  = bus_wr && tgt_ok;
    req_in.tgt  = tgt_sel;
    req_in.data = bus_wdata;
  end

  tmr_wr_sync #(.DLY(SYNC_DLY)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .req_out(req_land)
  );

  always_comb begin
    for (int i = 0; i < int'(N_TGT); i++)
      land[i] = req_land.vld && (req_land.tgt == tgt_e'(i));
  end

  assign w_cwst   = bus_wr && (bus_addr == A_CNT_WST);
  assign w_gwst   = bus_wr && (bus_addr == A_GWST);
  assign clr_stat = bus_wr && (bus_addr == A_ISTAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_run <= 1'b0; ctl_auto <= 1'b0; ctl_en <= 1'b0;
      ien     <= 1'b0;
      cnt_wst <= '0; cmp_wst <= '0; ctl_wst <= 1'b0;
    end else begin
      if (land[T_CTRL]) begin
        ctl_run  <= req_land.data[CTL_RUN_BIT];
        ctl_auto <= req_land.data[CTL_AUTO_BIT];
        ctl_en   <= req_land.data[CTL_CMPEN_BIT];
      end
      if (bus_wr && bus_addr == A_IEN) ien <= bus_wdata[0];
      for (int i = 0; i < 2; i++) begin
        if (land[int'(T_CNT_LO) + i])      cnt_wst[i] <= 1'b1;
        else if (w_cwst && bus_wdata[i])   cnt_wst[i] <= 1'b0;
      end
      for (int i = 0; i < 3; i++) begin
        if (land[int'(T_CMP_LO) + i])      cmp_wst[i] <= 1'b1;
        else if (w_gwst && bus_wdata[i])   cmp_wst[i] <= 1'b0;
      end
      if (land[T_CTRL])                            ctl_wst <= 1'b1;
      else if (w_gwst && bus_wdata[CTL_WST_BIT])   ctl_wst <= 1'b0;
    end
  end

  tmr_count u_count (
    .clk(clk), .rst_n(rst_n), .run(ctl_run),
    .ld_lo(land[T_CNT_LO]), .ld_hi(land[T_CNT_HI]),
    .ld_data(req_land.data), .cnt(cnt)
  );

  tmr_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt),
    .cmp_en(ctl_en), .auto_inc(ctl_auto),
    .ld_lo(land[T_CMP_LO]), .ld_hi(land[T_CMP_HI]), .ld_iv(land[T_IVAL]),
    .ld_data(req_land.data), .clr_stat(clr_stat),
    .cmp(cmp), .ival(ival), .stat(stat), .hit(hit)
  );

  assign irq = stat && ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO:  bus_rdata = cnt[HALF_W-1:0];
      A_CNT_HI:  bus_rdata = cnt[CNT_W-1:HALF_W];
      A_CNT_WST: bus_rdata = {30'd0, cnt_wst};
      A_CMP_LO:  bus_rdata = cmp[HALF_W-1:0];
      A_CMP_HI:  bus_rdata = cmp[CNT_W-1:HALF_W];
      A_IVAL:    bus_rdata = ival[HALF_W-1:0];
      A_CTRL: begin
        bus_rdata[CTL_RUN_BIT]   = ctl_run;
        bus_rdata[CTL_AUTO_BIT]  = ctl_auto;
        bus_rdata[CTL_CMPEN_BIT] = ctl_en;
      end
      A_ISTAT:   bus_rdata = {31'd0, stat};
      A_IEN:     bus_rdata = {31'd0, ien};
      A_GWST: begin
        bus_rdata[2:0]         = cmp_wst;
        bus_rdata[CTL_WST_BIT] = ctl_wst;
      end
      default:   bus_rdata = '0;
    endcase
  end

  // R2 R3
  ctl_land_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    land[T_CTRL] |=> ctl_wst);

  // R3
  ctl_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wst && !(w_gwst && bus_wdata[CTL_WST_BIT]) |=> ctl_wst);

  // R3
  cnt_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wst[0] && !(w_cwst && bus_wdata[0]) |=> cnt_wst[0]);

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  // R2
  one_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(land));
endmodule

// File: tb/test_gtimer_cmp.sv
`timescale 1ns/1ps
module test_gtimer_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gtimer_cmp i_gtimer_cmp (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam int LAND = 2;

  // expected values, computed from the requirements
  function automatic logic [63:0] after_ticks(input logic [63:0] v, input int n);
    return v + 64'(n);
  endfunction
  function automatic logic [63:0] next_point(input logic [63:0] c, input logic [63:0] i);
    logic [64:0] s;
    s = {1'b0, c} + {1'b0, i};
    return s[63:0];
  endfunction

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_land(input logic [11:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (LAND) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic rd64(input logic [11:0] lo_a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(lo_a, lo);
    rd(lo_a + 12'h4, hi);
    v = {hi, lo};
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, h1, h2, lo;
    logic [63:0] v64, base, prev, exp_cmp, step;
    bit found;
    void'($urandom(32'd1357));

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd(12'h100, v); check("R1 cnt_lo", v, 0);
    rd(12'h104, v); check("R1 cnt_hi", v, 0);
    rd(12'h200, v); check("R1 cmp_lo", v, 0);
    rd(12'h240, v); check("R1 ctrl", v, 0);
    rd(12'h244, v); check("R1 istat", v, 0);
    rd(12'h24C, v); check("R1 gwst", v, 0);
    check("R1 irq", irq, 0);

    // R2 landing delay, R3 flag rises on the landing edge
    wr(12'h100, 32'h1234_5678);
    rd(12'h100, v); check("R2 before E1", v, 0);
    wait_n(1);
    rd(12'h100, v); check("R2 before E2", v, 0);
    rd(12'h110, v); check("R3 flag not yet", v, 0);
    wait_n(1);
    rd(12'h100, v); check("R2 landed", v, 32'h1234_5678);
    rd(12'h110, v); check("R3 flag set", v, 1);
    wr(12'h110, 32'h2);
    rd(12'h110, v); check("R3 other bit W1C leaves flag", v, 1);
    wr(12'h110, 32'h0);
    rd(12'h110, v); check("R3 write 0 no effect", v, 1);
    wr(12'h110, 32'h1);
    rd(12'h110, v); check("R3 W1C clears", v, 0);

    // R6 random half loads with counter stopped
    for (int k = 0; k < 6; k++) begin
      logic [31:0] rl, rh;
      rl = $urandom; rh = $urandom;
      wr_land(12'h100, rl);
      rd64(12'h100, v64); check("R6 lo load keeps hi", v64[31:0], rl);
      wr_land(12'h104, rh);
      rd64(12'h100, v64); check("R6 hi load", v64, {rh, rl});
    end
    rd(12'h110, v); check("R3 both cnt flags", v, 3);

    // R4 counting and holding
    wr_land(12'h100, 32'h0000_0100);
    wr_land(12'h104, 32'h0);
    wr_land(12'h240, 32'h100);
    rd64(12'h100, base); check("R4 start value", base, 64'h100);
    wait_n(7);
    rd64(12'h100, v64); check("R4 count +7", v64, after_ticks(base, 7));
    rd(12'h24C, v); check("R3 ctrl flag", v[16], 1);
    wr_land(12'h240, 32'h0);
    rd64(12'h100, base);
    wait_n(5);
    rd64(12'h100, v64); check("R4 hold when stopped", v64, base);

    // R5 wrap
    wr_land(12'h100, 32'hFFFF_FFFF);
    wr_land(12'h104, 32'hFFFF_FFFF);
    wr_land(12'h240, 32'h100);
    rd64(12'h100, v64); check("R5 all ones", v64, 64'hFFFF_FFFF_FFFF_FFFF);
    wait_n(1);
    rd64(12'h100, v64); check("R5 wraps to zero", v64, 64'h0);
    wr_land(12'h240, 32'h0);

    // R11 hi/lo/hi reads across a carry
    wr_land(12'h100, 32'hFFFF_FFF0);
    wr_land(12'h104, 32'h7);
    wr_land(12'h240, 32'h100);
    prev = '0;
    for (int k = 0; k < 12; k++) begin
      rd(12'h104, h1); wait_n(1);
      rd(12'h100, lo); wait_n(1);
      rd(12'h104, h2); wait_n(1);
      if (h1 == h2) begin
        v64 = {h1, lo};
        check("R11 consistent hi", (h1 == 7 || h1 == 8), 1);
        check("R11 monotonic", (v64 > prev), 1);
        if (h1 == 8) check("R11 carry low small", (lo < 32'h100), 1);
        prev = v64;
      end
    end
    rd(12'h104, v); check("R11 carry reached hi", v, 8);
    wr_land(12'h240, 32'h0);

    // R7 R8 R9 R10 one-shot match with interrupt enable off first
    wr_land(12'h100, 32'h0);
    wr_land(12'h104, 32'h0);
    wr_land(12'h200, 32'd20);
    wr_land(12'h204, 32'h0);
    wr_land(12'h240, 32'h101);
    rd64(12'h100, v64); check("R7 start at 0", v64, 0);
    wait_n(20);
    rd64(12'h100, v64); check("R7 count at cmp", v64, 20);
    rd(12'h244, v); check("R7 not yet flagged", v, 0);
    wait_n(1);
    rd(12'h244, v); check("R7 match flagged", v, 1);
    rd64(12'h100, v64); check("R7 count past", v64, 21);
    rd64(12'h200, v64); check("R8 one-shot cmp kept", v64, 20);
    check("R10 irq gated by enable", irq, 0);
    wr(12'h248, 32'h1);
    check("R10 irq high", irq, 1);
    wr(12'h244, 32'h0);
    rd(12'h244, v); check("R9 write 0 no effect", v, 1);
    wr(12'h244, 32'h1);
    rd(12'h244, v); check("R9 W1C clears", v, 0);
    check("R10 irq low after clear", irq, 0);
    wait_n(30);
    rd(12'h244, v); check("R8 one-shot no rematch", v, 0);

    // R7 compare disabled: no match
    wr_land(12'h240, 32'h0);
    wr_land(12'h100, 32'h0);
    wr_land(12'h200, 32'd10);
    wr_land(12'h240, 32'h100);
    wait_n(30);
    rd(12'h244, v); check("R7 disabled no flag", v, 0);
    check("R10 irq stays low", irq, 0);
    wr_land(12'h240, 32'h0);

    // R8 periodic auto-increment, random start and interval
    wr_land(12'h100, 32'h0);
    wr_land(12'h104, 32'h0);
    exp_cmp = 64'(10 + ($urandom % 21));
    step    = 64'(6 + ($urandom % 25));
    wr_land(12'h200, exp_cmp[31:0]);
    wr_land(12'h204, 32'h0);
    wr_land(12'h208, step[31:0]);
    rd(12'h24C, v); check("R3 all compare flags", v, 32'h0001_0007);
    wr_land(12'h240, 32'h103);
    for (int r = 0; r < 6; r++) begin
      found = 1'b0;
      for (int t = 0; t < 200 && !found; t++) begin
        rd(12'h244, v);
        if (v[0]) found = 1'b1;
        else wait_n(1);
      end
      check("R8 periodic match seen", found, 1);
      rd64(12'h100, v64); check("R8 count one past point", v64, after_ticks(exp_cmp, 1));
      rd64(12'h200, v64); check("R8 cmp advanced", v64, next_point(exp_cmp, step));
      check("R10 irq on periodic", irq, 1);
      wr(12'h244, 32'h1);
      exp_cmp = next_point(exp_cmp, step);
    end
    wr_land(12'h240, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule